// File: doc/BRIEF.md
# Return-Address Stack with Full-Pointer Skip

This block holds the return addresses of a small processor in a 32-slot on-chip array and keeps a 5-bit pointer to the top entry. The sequencer raises a push request with a 14-bit address to save it, and raises a pop request to read the top entry back. Each request moves the pointer. Popped data appears on a registered output one clock later and stays there until the next pop.

When a push brings the pointer to its highest value, the block gives the sequencer a one-cycle skip pulse. The sequencer uses it the same way as the skip from its counting loop branches: it steps over the instruction after the push and lands in a spill handler. The block never stalls and never faults. A push past the top wraps the pointer. A pop below the bottom leaves the pointer at zero and returns slot 0.

Top module: `ret_stack_skip`

## Requirements
- R1: After reset the pointer is 0 (empty), the skip output is low, every slot holds 0 and the pop output reads 0.
- R2: A push with no pop first increments the pointer by one and then writes the push data into the slot the new pointer selects. The first push after reset therefore lands in slot 1.
- R3: A pop with no push loads the slot selected by the current pointer into the pop output, which is valid in the cycle after the pop edge, and then decrements the pointer. Data comes back in last-in, first-out order.
- R4: The skip output is high for exactly the one cycle after the edge of a push-only request that moves the pointer from 30 to 31. After reset, this is the 31st push.
- R5: The skip output is low in every other cycle, including the cycle after a pulse and after pops or pushes that leave the pointer at any other value.
- R6: A pop-only request while the pointer is 0 returns the content of slot 0 and leaves the pointer at 0.
- R7: A push-only request while the pointer is 31 wraps the pointer to 0, writes the data into slot 0 and does not raise skip.
- R8: A request with push and pop together returns the current top entry, overwrites that slot with the push data, leaves the pointer unchanged and does not raise skip.
- R9: The pop output holds its value in every cycle without a pop request.
- R10: The skip pulse repeats each time a push-only request brings the pointer back up to 31, for example after a pop from 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request for this cycle |
| pop_i | input | 1 | Pop request for this cycle |
| push_addr_i | input | 14 | Address to push |
| pop_addr_o | output | 14 | Last popped address, registered |
| skip_next_o | output | 1 | One-cycle skip pulse when the pointer reaches full |

## Verification
The bench builds the block with its default parameters: a 5-bit pointer and 14-bit entries. With these values a full pass of 31 pushes from reset takes only a few dozen cycles. That puts the full-pointer skip, the wrap into slot 0 and the repeat of the pulse after a pop within reach of short directed tests. Every slot is filled with distinct values, so the bench can tell a wrong slot index from a wrong pointer value.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } stk_op_e;

    function automatic stk_op_e decode_op(input logic push, input logic pop);
        return stk_op_e'({pop, push});
    endfunction
endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
    import ret_stack_pkg::*;
#(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic             rd_en_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             skip_o
);
    localparam logic [PTR_W-1:0] TOP_IDX  = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] ZERO_IDX = '0;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             skip;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    stk_op_e    op;
    logic [PTR_W-1:0] ptr_inc;

    always_comb begin
        op       = decode_op(push_i, pop_i);
        ptr_inc  = st_q.ptr + 1'b1;
        st_d     = st_q;
        st_d.skip = 1'b0;
        wr_en_o  = 1'b0;
        wr_idx_o = st_q.ptr;
        rd_en_o  = 1'b0;
        rd_idx_o = st_q.ptr;
        unique case (op)
            OP_PUSH: begin
                st_d.ptr  = ptr_inc;
                st_d.skip = (ptr_inc == TOP_IDX);
                wr_en_o   = 1'b1;
                wr_idx_o  = ptr_inc;
            end
            OP_POP: begin
                rd_en_o  = 1'b1;
                st_d.ptr = (st_q.ptr == ZERO_IDX) ? ZERO_IDX : st_q.ptr - 1'b1;
            end
            OP_SWAP: begin
                rd_en_o = 1'b1;
                wr_en_o = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign skip_o = st_q.skip;

    // R2
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (st_q.ptr == PTR_W'($past(st_q.ptr) + 1'b1)));

    // R4
    skip_on_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && st_q.ptr == TOP_IDX - 1'b1) |=> skip_o);

    // R5
    skip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> !skip_o);

    // R6
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && st_q.ptr == ZERO_IDX) |=> (st_q.ptr == ZERO_IDX));

    // R8
    swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> ($stable(st_q.ptr) && !skip_o));
endmodule

// File: rtl/ret_stack_store.sv
module ret_stack_store #(
    parameter int PTR_W  = 5,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] slot_d [DEPTH];
    logic [DATA_W-1:0] slot_q [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        slot_d = slot_q;
        rd_d   = rd_q;
        if (rd_en_i) rd_d = slot_q[rd_idx_i];
        if (wr_en_i) slot_d[wr_idx_i] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            rd_q   <= rd_d;
            slot_q <= slot_d;
        end
    end

    assign rd_data_o = rd_q;

    // R9
    pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/ret_stack_skip.sv
module ret_stack_skip #(
    parameter int PTR_W  = 5,
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] push_addr_i,
    output logic [DATA_W-1:0] pop_addr_o,
    output logic              skip_next_o
);
    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;

    ret_stack_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_en_o  (rd_en),
        .rd_idx_o (rd_idx),
        .skip_o   (skip_next_o)
    );

    ret_stack_store #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_addr_i),
        .rd_en_i   (rd_en),
        .rd_idx_i  (rd_idx),
        .rd_data_o (pop_addr_o)
    );

    // R7
    wrap_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && skip_next_o) |=> !skip_next_o);
endmodule

// File: tb/sim_ret_stack_skip.sv
module sim_ret_stack_skip;
    localparam int DW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          skip;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    ret_stack_skip u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_addr_i (din),
        .pop_addr_o  (dout),
        .skip_next_o (skip)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push = 1'b0; pop = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic op(input logic p, input logic q, input logic [DW-1:0] v);
        push = p; pop = q; din = v;
        @(negedge clk);
        push = 1'b0; pop = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 311 + 17);
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 skip", {13'd0, skip}, 14'd0);
        chk("R1 pop out", dout, 14'd0);
        op(0, 1, 0);
        chk("R6 empty pop", dout, 14'd0);
        chk("R5 no skip on pop", {13'd0, skip}, 14'd0);
    endtask

    task automatic t_lifo();
        do_reset();
        op(1, 0, 14'h0abc);
        chk("R5 no skip", {13'd0, skip}, 14'd0);
        op(1, 0, 14'h1234);
        op(1, 0, 14'h3fff);
        op(0, 1, 0);
        chk("R3 top", dout, 14'h3fff);
        op(0, 0, 0);
        op(0, 0, 0);
        chk("R9 hold", dout, 14'h3fff);
        op(0, 1, 0);
        chk("R3 mid", dout, 14'h1234);
        op(0, 1, 0);
        chk("R2 first push in slot 1", dout, 14'h0abc);
        op(0, 1, 0);
        chk("R6 reaches slot 0", dout, 14'd0);
    endtask

    task automatic t_full();
        int bad_skip = 0;
        do_reset();
        for (int i = 1; i <= 30; i++) begin
            op(1, 0, pat(i));
            if (skip !== 1'b0) bad_skip++;
        end
        chk("R5 no early skip", DW'(bad_skip), 14'd0);
        op(1, 0, pat(31));
        chk("R4 skip at 31", {13'd0, skip}, 14'd1);
        op(0, 0, 0);
        chk("R5 pulse one cycle", {13'd0, skip}, 14'd0);
        op(0, 1, 0);
        chk("R3 pop at 31", dout, pat(31));
        op(1, 0, 14'h2222);
        chk("R10 skip again", {13'd0, skip}, 14'd1);
        op(1, 0, 14'h1111);
        chk("R7 wrap no skip", {13'd0, skip}, 14'd0);
        op(0, 1, 0);
        chk("R7 slot 0 written", dout, 14'h1111);
        op(0, 1, 0);
        chk("R6 pointer held at 0", dout, 14'h1111);
        op(1, 0, 14'h0555);
        op(0, 1, 0);
        chk("R7 pointer was 0", dout, 14'h0555);
    endtask

    task automatic t_swap();
        int bad_skip = 0;
        do_reset();
        op(1, 0, 14'h0a0a);
        op(1, 0, 14'h0b0b);
        op(1, 1, 14'h0c0c);
        chk("R8 swap returns top", dout, 14'h0b0b);
        chk("R8 swap no skip", {13'd0, skip}, 14'd0);
        op(0, 1, 0);
        chk("R8 top replaced", dout, 14'h0c0c);
        op(0, 1, 0);
        chk("R8 pointer unchanged", dout, 14'h0a0a);
        do_reset();
        for (int i = 1; i <= 30; i++) op(1, 0, pat(i));
        op(1, 1, 14'h0777);
        if (skip !== 1'b0) bad_skip++;
        chk("R8 swap at 30 no skip", DW'(bad_skip), 14'd0);
        chk("R8 swap at 30 data", dout, pat(30));
        op(1, 0, 14'h0888);
        chk("R4 push to 31 after swap", {13'd0, skip}, 14'd1);
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lifo();
        t_full();
        t_swap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule